// File: doc/BRIEF.md
# CAN Operating-Mode and Sleep Controller

This block keeps the operating-mode state of a CAN controller: a configuration hold (reset mode), listen-only, self-test and sleep. Software changes the mode through a small register write port. The block takes a bus-activity flag, a bit strobe that fires once per bit time with the sampled bit level, and an OR of all pending controller interrupts. From these it decides when the controller may sleep and when it has to wake. A sleep request is not always granted. A refused request and every wake-up give a one-cycle wake-up interrupt pulse to an external interrupt-status register.

Reception is qualified by `rx_enable`. It is low in reset mode and during sleep. After a wake-up caused by bus traffic, it also stays low until the controller has counted a bus-free run of eleven consecutive recessive bits. The same bus-free run is needed after reset mode is left, before the first sleep request can be granted. Bit timing, the protocol engine and acceptance filtering are handled outside this block.

Top module: `can_mode_ctrl`

## Requirements
- R1: Out of system reset the hold (reset-mode) bit is 1. Listen-only, self-test and sleeping are 0, `wake_irq` is 0 and `rx_enable` is 0.
- R2: The listen-only field (`wr_data[1]`) and the self-test field (`wr_data[2]`) are taken only when the hold bit already reads 1 before the write. This holds even when the same write clears the hold bit. At any other time both bits keep their value.
- R3: A write takes effect only when `wr_en` is high and byte lane 0 (`wr_be[0]`) is enabled. The hold field is `wr_data[0]` and can be written at any time. All register outputs change at the clock edge that samples the write.
- R4: A write with the sleep field (`wr_data[3]`) at 1 and the hold field at 0 enters sleep at that edge when all of these are true: hold reads 0, the controller is armed, `bus_active` is 0 and `irq_pending` is 0.
- R5: The same sleep request, when armed and out of hold but with `bus_active` or `irq_pending` high, does not enter sleep. It gives one `wake_irq` pulse in the next cycle.
- R6: A sleep request made while hold reads 1, or while the controller is not armed, is ignored. It neither sleeps nor raises `wake_irq`.
- R7: While sleeping, a write with the sleep field at 0 wakes the controller and gives one `wake_irq` pulse. With hold at 0, `rx_enable` goes high at the same edge.
- R8: While sleeping, `bus_active` high wakes the controller and gives one `wake_irq` pulse. `rx_enable` then stays low until eleven consecutive recessive bit strobes have been seen after the wake-up.
- R9: The bus-free counter advances on each strobe with `bit_recessive` high. It restarts from zero on a strobe with `bit_recessive` low, and stops at eleven. It is held at zero in hold and restarts at a bus-triggered wake-up. `rx_enable` rises in the cycle after the eleventh recessive strobe.
- R10: The arm flag is cleared while hold reads 1. Once hold is 0, it is set after a bus-free run of eleven recessive bits. Only then can a sleep request be granted.
- R11: `wake_irq` is high for exactly one cycle per wake-up or refused request. It is registered and rises in the cycle after the event.
- R12: While sleeping, a write with the hold field at 1 sets hold, ends sleep and gives one `wake_irq` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_be | input | DATA_W/8 | Byte enables of the write, lane 0 carries the mode fields |
| wr_data | input | DATA_W | Write data: bit 0 hold, 1 listen-only, 2 self-test, 3 sleep |
| bus_active | input | 1 | Bus activity seen on the CAN lines |
| bit_strobe | input | 1 | One-cycle strobe per bit time |
| bit_recessive | input | 1 | Sampled bit level at the strobe, 1 = recessive |
| irq_pending | input | 1 | OR of all pending controller interrupts |
| mode_hold | output | 1 | Reset-mode (configuration hold) bit |
| mode_listen | output | 1 | Listen-only mode bit |
| mode_selftest | output | 1 | Self-test mode bit |
| sleeping | output | 1 | Sleep bit, controller asleep |
| wake_irq | output | 1 | One-cycle wake-up interrupt pulse |
| rx_enable | output | 1 | Receiver enable qualifier |

## Verification
The bench goes after the order-sensitive corners. One is a listen-only write made in the same cycle as hold is cleared; a design that checked the new hold value would drop that write. Another is a sleep request made before any bus-free run, or while in hold. A design that skipped the arm check would sleep, or would raise a stray interrupt. Further corners are sleep requests refused because of bus activity or a pending interrupt; a design that got these wrong would sleep through traffic, or would stay silent with no interrupt. Finally, a bus-triggered wake-up is followed by a recessive run broken by a dominant bit, which shows whether the counter restarts; a counter that only paused would enable reception too early. A long random phase compares every output against the behavioural model on every cycle.

// File: rtl/can_mode_pkg.sv
// Package: shared field positions and limits for the CAN mode controller.
package can_mode_pkg;
    // Field positions in byte lane 0 of the mode write.
    localparam int HOLD_BIT     = 0;
    localparam int LISTEN_BIT   = 1;
    localparam int SELFTEST_BIT = 2;
    localparam int SLEEP_BIT    = 3;
    localparam int MODE_W       = 4;

    // Decoded view of one mode write.
    typedef struct packed {
        logic sleep;
        logic selftest;
        logic listen;
        logic hold;
    } mode_wr_t;
endpackage

// File: rtl/can_busfree_cnt.sv
// Module: can_busfree_cnt
// Counts consecutive recessive bits, one per bit strobe, and stops at LIMIT.
// A dominant strobe restarts the count. A synchronous clear has priority.
// Assumes: the bit strobe is one cycle wide per bit time.
module can_busfree_cnt #(
    parameter int LIMIT = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_strobe,
    input  logic bit_recessive,
    output logic bus_free
);
    localparam int CNT_W = $clog2(LIMIT + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

    logic [CNT_W-1:0] cnt_q;

    // Purpose: count recessive bits, restart on dominant, stop at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (bit_strobe) begin
            if (!bit_recessive)
                cnt_q <= '0;
            else if (cnt_q != CNT_MAX)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    assign bus_free = (cnt_q == CNT_MAX);
endmodule

// File: rtl/can_mode_regs.sv
// Module: can_mode_regs
// Holds the hold, listen-only and self-test bits. Listen-only and self-test
// are written only while hold already reads 1 (the value before the write).
// Assumes: wr_fire is the qualified write strobe of byte lane 0.
module can_mode_regs
    import can_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_fire,
    input  mode_wr_t wr_fields,
    output logic     hold_q,
    output logic     listen_q,
    output logic     selftest_q
);
    // Purpose: hold bit, writable at any time, set out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= 1'b1;
        else if (wr_fire)
            hold_q <= wr_fields.hold;
    end

    // Purpose: protected mode bits, gated by the current hold value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            listen_q   <= 1'b0;
            selftest_q <= 1'b0;
        end else if (wr_fire && hold_q) begin
            listen_q   <= wr_fields.listen;
            selftest_q <= wr_fields.selftest;
        end
    end
endmodule

// File: rtl/can_sleep_ctl.sv
// Module: can_sleep_ctl
// Sleep entry and refusal, wake-up sources, arm flag, receive block after a
// bus-triggered wake-up, and the registered wake-up interrupt pulse.
// Assumes: bus_free comes from the recessive-bit counter that this block clears.
module can_sleep_ctl
    import can_mode_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_fire,
    input  mode_wr_t wr_fields,
    input  logic     hold_q,
    input  logic     bus_active,
    input  logic     irq_pending,
    input  logic     bus_free,
    output logic     sleep_q,
    output logic     wake_irq,
    output logic     rx_block,
    output logic     cnt_clear
);
    logic armed_q;
    logic bus_wake, any_wake, try_sleep, grant, refuse;

    // Purpose: decode wake-ups and sleep requests for this cycle.
    always_comb begin
        bus_wake  = sleep_q && bus_active;
        any_wake  = sleep_q && (bus_active ||
                    (wr_fire && (!wr_fields.sleep || wr_fields.hold)));
        try_sleep = !sleep_q && wr_fire && wr_fields.sleep && !wr_fields.hold
                    && !hold_q && armed_q;
        grant     = try_sleep && !bus_active && !irq_pending;
        refuse    = try_sleep && !grant;
        cnt_clear = hold_q || bus_wake;
    end

    // Purpose: sleep state and the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sleep_q  <= 1'b0;
            wake_irq <= 1'b0;
        end else begin
            sleep_q  <= sleep_q ? !any_wake : grant;
            wake_irq <= any_wake || refuse;
        end
    end

    // Purpose: arm flag, cleared in hold, set by a bus-free run.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_q)
            armed_q <= 1'b0;
        else if (bus_free)
            armed_q <= 1'b1;
    end

    // Purpose: block reception after a bus-triggered wake until bus-free.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_block <= 1'b0;
        else if (bus_wake)
            rx_block <= 1'b1;
        else if (bus_free || hold_q)
            rx_block <= 1'b0;
    end
endmodule

// File: rtl/can_mode_ctrl.sv
// Module: can_mode_ctrl (top)
// Operating-mode and sleep controller of a CAN node. It decodes the mode write
// and connects the mode registers, the sleep control and the bus-free counter.
// Assumes: the mode fields live in byte lane 0, and upper data bits are ignored.
module can_mode_ctrl
    import can_mode_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int BUSFREE_LEN = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W/8-1:0] wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              bus_active,
    input  logic              bit_strobe,
    input  logic              bit_recessive,
    input  logic              irq_pending,
    output logic              mode_hold,
    output logic              mode_listen,
    output logic              mode_selftest,
    output logic              sleeping,
    output logic              wake_irq,
    output logic              rx_enable
);
    localparam int BE_W = DATA_W / 8;

    logic     wr_fire, bus_free, cnt_clear, rx_block;
    mode_wr_t wr_fields;
    logic     unused_bits;

    // Purpose: qualify the write and pick the mode fields.
    always_comb begin
        wr_fire   = wr_en && wr_be[0];
        wr_fields = mode_wr_t'(wr_data[MODE_W-1:0]);
    end

    assign unused_bits = ^{wr_data[DATA_W-1:MODE_W], wr_be[BE_W-1:0]};

    can_mode_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .wr_fields  (wr_fields),
        .hold_q     (mode_hold),
        .listen_q   (mode_listen),
        .selftest_q (mode_selftest)
    );

    can_sleep_ctl u_sleep (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_fire     (wr_fire),
        .wr_fields   (wr_fields),
        .hold_q      (mode_hold),
        .bus_active  (bus_active),
        .irq_pending (irq_pending),
        .bus_free    (bus_free),
        .sleep_q     (sleeping),
        .wake_irq    (wake_irq),
        .rx_block    (rx_block),
        .cnt_clear   (cnt_clear)
    );

    can_busfree_cnt #(.LIMIT(BUSFREE_LEN)) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .clear         (cnt_clear),
        .bit_strobe    (bit_strobe),
        .bit_recessive (bit_recessive),
        .bus_free      (bus_free)
    );

    // Purpose: reception only when out of hold, awake and not blocked.
    assign rx_enable = !mode_hold && !sleeping && !rx_block;
endmodule

// File: rtl/can_mode_ctrl_chk.sv
// Module: can_mode_ctrl_chk
// Assertion checker bound to can_mode_ctrl. It observes ports only.
module can_mode_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic bus_active,
    input logic irq_pending,
    input logic mode_hold,
    input logic mode_listen,
    input logic mode_selftest,
    input logic sleeping,
    input logic wake_irq,
    input logic rx_enable
);
    // R2: protected bits keep their value while hold reads 0
    a_r2_protected_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_hold |=> $stable(mode_listen) && $stable(mode_selftest));

    // R6: never asleep while in hold
    a_r6_no_sleep_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        mode_hold |-> !sleeping);

    // R4: sleep is entered only on a quiet bus with nothing pending
    a_r4_clean_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleeping) |-> $past(!bus_active && !irq_pending && wr_en));

    // R8: every end of sleep raises the wake interrupt
    a_r8_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sleeping) |-> wake_irq);

    // R8: no reception while asleep or in hold
    a_r8_rx_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping || mode_hold) |-> !rx_enable);

    // R11: the interrupt has a cause in the previous cycle
    a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wake_irq |-> $past(wr_en || bus_active));
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .bus_active    (bus_active),
    .irq_pending   (irq_pending),
    .mode_hold     (mode_hold),
    .mode_listen   (mode_listen),
    .mode_selftest (mode_selftest),
    .sleeping      (sleeping),
    .wake_irq      (wake_irq),
    .rx_enable     (rx_enable)
);

// File: tb/can_mode_ctrl_bench.sv
// Bench: behavioural reference model of the mode controller, compared on
// every cycle, plus directed checks tagged with requirements.
module can_mode_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [0:0] wr_be = 1'b0;
    logic [7:0] wr_data = '0;
    logic       bus_active = 1'b0, bit_strobe = 1'b0, bit_recessive = 1'b0;
    logic       irq_pending = 1'b0;
    logic       mode_hold, mode_listen, mode_selftest, sleeping, wake_irq, rx_enable;

    int checks = 0;
    int failures = 0;

    // Reference model state.
    bit m_hold, m_listen, m_st, m_sleep, m_irq, m_armed, m_block;
    int m_run;

    always #2 clk = ~clk;

    can_mode_ctrl u_can_mode_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data),
        .bus_active(bus_active), .bit_strobe(bit_strobe), .bit_recessive(bit_recessive),
        .irq_pending(irq_pending), .mode_hold(mode_hold), .mode_listen(mode_listen),
        .mode_selftest(mode_selftest), .sleeping(sleeping), .wake_irq(wake_irq),
        .rx_enable(rx_enable)
    );

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_hold = 1; m_listen = 0; m_st = 0; m_sleep = 0; m_irq = 0;
        m_armed = 0; m_block = 0; m_run = 0;
    endtask

    // One clock: predict from the driven inputs, advance, compare at negedge.
    task automatic step(string req);
        bit wr, wake, bwake, want, n_sleep, n_irq, n_armed, n_block, n_hold, n_l, n_s;
        int n_run;
        wr    = wr_en && wr_be[0];
        bwake = m_sleep && bus_active;
        wake  = m_sleep && (bus_active || (wr && (!wr_data[3] || wr_data[0])));
        want  = !m_sleep && wr && wr_data[3] && !wr_data[0] && !m_hold && m_armed;
        n_hold = wr ? wr_data[0] : m_hold;
        n_l = (wr && m_hold) ? wr_data[1] : m_listen;
        n_s = (wr && m_hold) ? wr_data[2] : m_st;
        if (m_sleep) n_sleep = !wake;
        else         n_sleep = want && !bus_active && !irq_pending;
        n_irq = wake || (want && (bus_active || irq_pending));
        n_armed = m_hold ? 0 : (m_armed || m_run == 11);
        if (bwake) n_block = 1;
        else if (m_run == 11 || m_hold) n_block = 0;
        else n_block = m_block;
        if (m_hold || bwake) n_run = 0;
        else if (bit_strobe) n_run = bit_recessive ? ((m_run < 11) ? m_run + 1 : 11) : 0;
        else n_run = m_run;
        @(posedge clk);
        m_hold = n_hold; m_listen = n_l; m_st = n_s; m_sleep = n_sleep; m_irq = n_irq;
        m_armed = n_armed; m_block = n_block; m_run = n_run;
        @(negedge clk);
        chk(req, "mode_hold", mode_hold, m_hold);
        chk(req, "mode_listen", mode_listen, m_listen);
        chk(req, "mode_selftest", mode_selftest, m_st);
        chk(req, "sleeping", sleeping, m_sleep);
        chk(req, "wake_irq", wake_irq, m_irq);
        chk(req, "rx_enable", rx_enable, !m_hold && !m_sleep && !m_block);
    endtask

    task automatic idle_inputs();
        wr_en = 0; wr_be = 1'b0; wr_data = '0; bus_active = 0;
        bit_strobe = 0; bit_recessive = 0; irq_pending = 0;
    endtask

    task automatic write(string req, bit [3:0] f, bit be = 1'b1);
        wr_en = 1; wr_be = be; wr_data = {4'hA, f};
        step(req);
        idle_inputs();
    endtask

    task automatic bits(string req, int n, bit rec);
        for (int i = 0; i < n; i++) begin
            bit_strobe = 1; bit_recessive = rec;
            step(req);
            bit_strobe = 0;
            step(req);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        chk("R1", "hold", mode_hold, 1);
        chk("R1", "listen", mode_listen, 0);
        chk("R1", "sleeping", sleeping, 0);
        chk("R1", "wake_irq", wake_irq, 0);
        chk("R1", "rx_enable", rx_enable, 0);

        // R3: a write with lane 0 disabled changes nothing
        write("R3", 4'b0000, 1'b0);
        chk("R3", "hold kept", mode_hold, 1);
        // R2: listen set while in hold, and accepted on the write that clears hold
        write("R2", 4'b0011);
        chk("R2", "listen in hold", mode_listen, 1);
        write("R2", 4'b0100);
        chk("R2", "same-write selftest", mode_selftest, 1);
        chk("R3", "hold cleared", mode_hold, 0);
        write("R2", 4'b0010);
        chk("R2", "listen ignored out of hold", mode_listen, 0);
        chk("R2", "selftest kept", mode_selftest, 1);
        write("R2", 4'b0001);
        write("R2", 4'b0000);

        // R6: sleep while not armed is ignored
        write("R6", 4'b1000);
        chk("R6", "no sleep unarmed", sleeping, 0);
        chk("R6", "no irq unarmed", wake_irq, 0);
        // R9: a broken run restarts, then eleven recessive arm (R10)
        bits("R9", 6, 1'b1);
        bits("R9", 1, 1'b0);
        bits("R10", 10, 1'b1);
        write("R10", 4'b1000);
        chk("R10", "ten bits do not arm", sleeping, 0);
        bits("R10", 1, 1'b1);
        step("R10");

        // R5: refused requests
        bus_active = 1;
        write("R5", 4'b1000);
        chk("R5", "refused by bus", sleeping, 0);
        chk("R5", "refuse irq", wake_irq, 1);
        step("R11");
        chk("R11", "pulse one cycle", wake_irq, 0);
        irq_pending = 1;
        write("R5", 4'b1000);
        chk("R5", "refused by pending", sleeping, 0);
        chk("R5", "refuse irq pending", wake_irq, 1);

        // R4 and R7: sleep, then software wake
        write("R4", 4'b1000);
        chk("R4", "asleep", sleeping, 1);
        chk("R4", "rx off asleep", rx_enable, 0);
        write("R7", 4'b0000);
        chk("R7", "awake", sleeping, 0);
        chk("R7", "wake irq", wake_irq, 1);
        chk("R7", "rx on", rx_enable, 1);

        // R8: bus wake blocks reception until a full bus-free run
        write("R8", 4'b1000);
        bus_active = 1;
        step("R8");
        bus_active = 0;
        chk("R8", "bus wake", sleeping, 0);
        chk("R8", "bus wake irq", wake_irq, 1);
        chk("R8", "rx blocked", rx_enable, 0);
        bits("R8", 10, 1'b1);
        bits("R9", 1, 1'b0);
        bits("R8", 10, 1'b1);
        chk("R9", "still blocked at ten", rx_enable, 0);
        bit_strobe = 1; bit_recessive = 1;
        step("R8");
        idle_inputs();
        chk("R8", "blocked on eleventh edge", rx_enable, 0);
        step("R8");
        chk("R8", "rx enabled after run", rx_enable, 1);

        // R12: hold write while sleeping
        write("R12", 4'b1000);
        chk("R12", "asleep", sleeping, 1);
        write("R12", 4'b1001);
        chk("R12", "hold set", mode_hold, 1);
        chk("R12", "woken", sleeping, 0);
        chk("R12", "irq", wake_irq, 1);
        // R6: sleep request in hold ignored
        write("R6", 4'b1001);
        chk("R6", "no sleep in hold", sleeping, 0);
        chk("R6", "no irq in hold", wake_irq, 0);

        // Random phase against the model
        write("R3", 4'b0000);
        for (int i = 0; i < 3000; i++) begin
            wr_en = ($urandom_range(0, 7) == 0);
            wr_be = 1'($urandom_range(0, 3) != 0);
            wr_data = 8'($urandom_range(0, 255));
            if (wr_data[0] && $urandom_range(0, 3) != 0) wr_data[0] = 0;
            bus_active = ($urandom_range(0, 29) == 0);
            irq_pending = ($urandom_range(0, 9) == 0);
            bit_strobe = $urandom_range(0, 1);
            bit_recessive = ($urandom_range(0, 15) != 0);
            step("R11");
        end
        idle_inputs();
        step("R11");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule